// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns an addressing-mode request into a 20-bit linear memory address. It first forms a 16-bit effective address from up to three inputs: a base register value, an index register value and a displacement constant. In one mode the index is first multiplied by a power-of-two scale. The block then picks a 16-bit segment value, shifts it left by four bits to make the segment base, and adds the effective address to that base.

The segment choice follows the base register. A mode whose base register is the stack pointer or the frame pointer uses the stack segment. Every other mode, including the constant-only mode, uses the data segment. The caller reports which case applies on `base_is_stack`.

All results are available combinationally in the same cycle as the inputs. A registered copy of the results, qualified by `out_valid`, appears one clock after a cycle in which `in_valid` is high.

Top module: `seg_lin_addr_gen`

## Requirements
- R1: `lin_addr` equals (selected segment value × 16 + `ea`) modulo 2^20. A carry out of bit 19 is dropped, so `lin_addr[3:0]` always equals `ea[3:0]`.
- R2: Mode 3'd0 (direct) gives `ea` = `disp` and `seg_sel` = 0 (data segment).
- R3: Mode 3'd1 (register indirect) gives `ea` = `base_val`.
- R4: Mode 3'd2 (based-indexed) gives `ea` = (`base_val` + `index_val`) mod 2^16.
- R5: Mode 3'd3 (register relative) gives `ea` = (`base_val` + `disp`) mod 2^16.
- R6: Mode 3'd4 (base relative plus index) gives `ea` = (`base_val` + `index_val` + `disp`) mod 2^16.
- R7: Mode 3'd5 (scaled index) gives `ea` = (`base_val` + `index_val` × 2^`scale_code`) mod 2^16. Scale codes 0, 1, 2 and 3 select 1, 2, 4 and 8.
- R8: In modes 3'd1 to 3'd5, `seg_sel` equals `base_is_stack`. An output of 1 selects `seg_stack` and 0 selects `seg_data`.
- R9: Codes 3'd6 and 3'd7 behave exactly like direct mode.
- R10: One cycle after a clock edge that samples `in_valid` = 1, `out_valid` is 1 and `ea_q`, `seg_sel_q` and `lin_q` hold the combinational results of the sampled cycle. After an edge that samples `in_valid` = 0, `out_valid` is 0 and the registered results keep their values.
- R11: While `rst_n` is low, `out_valid`, `ea_q`, `seg_sel_q` and `lin_q` are all 0.
- R12: `scale_code` has no effect on any output in modes other than 3'd5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| in_valid | input | 1 | Qualifies the inputs for capture into the output register |
| mode | input | 3 | Addressing mode code |
| base_val | input | 16 | Base register value |
| index_val | input | 16 | Index register value |
| disp | input | 16 | Displacement constant |
| scale_code | input | 2 | Index scale: 1, 2, 4 or 8 |
| base_is_stack | input | 1 | Base register is the stack or frame pointer |
| seg_data | input | 16 | Data segment value |
| seg_stack | input | 16 | Stack segment value |
| ea | output | 16 | Effective address (combinational) |
| seg_sel | output | 1 | Chosen segment: 0 data, 1 stack (combinational) |
| lin_addr | output | 20 | Linear address (combinational) |
| out_valid | output | 1 | Registered results valid |
| ea_q | output | 16 | Registered effective address |
| seg_sel_q | output | 1 | Registered segment choice |
| lin_q | output | 20 | Registered linear address |

## Verification
Two kinds of wrap can occur in the same cycle. The effective-address sum can overflow 16 bits, and the segment-base addition can then overflow 20 bits. The bench sets up both at once: a stack segment of 16'hFFFF together with a scaled or three-operand sum that crosses 16'hFFFF. It then checks the combinational outputs and the registered copy against a model that truncates at each of the two stages separately. The bench also changes the inputs while `in_valid` is low, in the cycle after the last capture. This shows that the registered results hold while the combinational outputs follow the new inputs.

// File: rtl/slag_pkg.sv
package slag_pkg;

   typedef enum logic [2:0] {
      AM_DIRECT   = 3'd0,
      AM_REG_IND  = 3'd1,
      AM_BASE_IDX = 3'd2,
      AM_REG_REL  = 3'd3,
      AM_BREL_IDX = 3'd4,
      AM_SCALED   = 3'd5,
      AM_RSV6     = 3'd6,
      AM_RSV7     = 3'd7
   } amode_e;

   typedef enum logic {
      SEG_IS_DATA  = 1'b0,
      SEG_IS_STACK = 1'b1
   } segsel_e;

endpackage

// File: rtl/slag_ea_unit.sv
module slag_ea_unit #(
   parameter int EA_W    = 16,
   parameter int SCALE_W = 2
) (
   input  slag_pkg::amode_e    mode,
   input  logic [EA_W-1:0]     base_val,
   input  logic [EA_W-1:0]     index_val,
   input  logic [EA_W-1:0]     disp,
   input  logic [SCALE_W-1:0]  scale_code,
   output logic [EA_W-1:0]     ea,
   output logic                uses_base
);
   import slag_pkg::*;

   localparam int MAX_SHIFT = (1 << SCALE_W) - 1;

   logic [EA_W-1:0] idx_scaled;
   logic [EA_W-1:0] sum_bi;
   logic [EA_W-1:0] sum_bd;
   logic [EA_W-1:0] sum_bid;
   logic [EA_W-1:0] sum_bs;

   // barrel shift of the index, one stage per scale-code bit
   logic [EA_W-1:0] shift_stage [SCALE_W+1];
   assign shift_stage[0] = index_val;
   for (genvar s = 0; s < SCALE_W; s++) begin : g_shift
      assign shift_stage[s+1] = scale_code[s] ? (shift_stage[s] << (1 << s))
                                              : shift_stage[s];
   end
   assign idx_scaled = shift_stage[SCALE_W];

   if (MAX_SHIFT >= EA_W) begin : g_chk_scale
      $error("slag_ea_unit: scale range exceeds EA width");
   end

   assign sum_bi  = base_val + index_val;
   assign sum_bd  = base_val + disp;
   assign sum_bid = sum_bi + disp;
   assign sum_bs  = base_val + idx_scaled;

   always_comb begin
      ea        = disp;
      uses_base = 1'b0;
      unique case (mode)
         AM_REG_IND:  begin ea = base_val; uses_base = 1'b1; end
         AM_BASE_IDX: begin ea = sum_bi;   uses_base = 1'b1; end
         AM_REG_REL:  begin ea = sum_bd;   uses_base = 1'b1; end
         AM_BREL_IDX: begin ea = sum_bid;  uses_base = 1'b1; end
         AM_SCALED:   begin ea = sum_bs;   uses_base = 1'b1; end
         default:     begin ea = disp;     uses_base = 1'b0; end
      endcase
   end

endmodule

// File: rtl/slag_seg_select.sv
module slag_seg_select #(
   parameter int SEG_W = 16
) (
   input  logic              uses_base,
   input  logic              base_is_stack,
   input  logic [SEG_W-1:0]  seg_data,
   input  logic [SEG_W-1:0]  seg_stack,
   output slag_pkg::segsel_e seg_sel,
   output logic [SEG_W-1:0]  seg_val
);
   import slag_pkg::*;

   always_comb begin
      seg_sel = (uses_base && base_is_stack) ? SEG_IS_STACK : SEG_IS_DATA;
      seg_val = (seg_sel == SEG_IS_STACK) ? seg_stack : seg_data;
   end

endmodule

// File: rtl/slag_lin_adder.sv
module slag_lin_adder #(
   parameter int EA_W      = 16,
   parameter int SEG_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int LIN_W     = 20
) (
   input  logic [SEG_W-1:0] seg_val,
   input  logic [EA_W-1:0]  ea,
   output logic [LIN_W-1:0] lin_addr
);
   localparam int BASE_W = SEG_W + SEG_SHIFT;

   logic [BASE_W-1:0] seg_base;
   logic [LIN_W-1:0]  base_ext;
   logic [LIN_W-1:0]  ea_ext;

   if (SEG_SHIFT > 0) begin : g_shifted
      assign seg_base = {seg_val, {SEG_SHIFT{1'b0}}};
   end else begin : g_flat
      assign seg_base = seg_val;
   end

   if (BASE_W > LIN_W) begin : g_base_trunc
      assign base_ext = seg_base[LIN_W-1:0];
   end else if (BASE_W == LIN_W) begin : g_base_eq
      assign base_ext = seg_base;
   end else begin : g_base_pad
      assign base_ext = {{(LIN_W-BASE_W){1'b0}}, seg_base};
   end

   if (LIN_W > EA_W) begin : g_ea_pad
      assign ea_ext = {{(LIN_W-EA_W){1'b0}}, ea};
   end else begin : g_ea_eq
      assign ea_ext = ea[LIN_W-1:0];
   end

   // carry out of the top bit is discarded
   assign lin_addr = base_ext + ea_ext;

endmodule

// File: rtl/seg_lin_addr_gen.sv
module seg_lin_addr_gen #(
   parameter int EA_W      = 16,
   parameter int SEG_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int SCALE_W   = 2,
   parameter int LIN_W     = SEG_W + SEG_SHIFT,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        mode,
   input  logic [EA_W-1:0]   base_val,
   input  logic [EA_W-1:0]   index_val,
   input  logic [EA_W-1:0]   disp,
   input  logic [SCALE_W-1:0] scale_code,
   input  logic              base_is_stack,
   input  logic [SEG_W-1:0]  seg_data,
   input  logic [SEG_W-1:0]  seg_stack,
   output logic [EA_W-1:0]   ea,
   output logic              seg_sel,
   output logic [LIN_W-1:0]  lin_addr,
   output logic              out_valid,
   output logic [EA_W-1:0]   ea_q,
   output logic              seg_sel_q,
   output logic [LIN_W-1:0]  lin_q
);
   import slag_pkg::*;

   if (EA_W < 1 || SEG_W < 1) begin : g_chk_w
      $error("seg_lin_addr_gen: widths must be positive");
   end
   if (LIN_W < EA_W) begin : g_chk_lin
      $error("seg_lin_addr_gen: linear width below EA width");
   end

   amode_e            mode_e;
   logic              uses_base;
   segsel_e           sel_e;
   logic [SEG_W-1:0]  seg_val;

   assign mode_e = amode_e'(mode);

   slag_ea_unit #(.EA_W(EA_W), .SCALE_W(SCALE_W)) u_ea (
      .mode       (mode_e),
      .base_val   (base_val),
      .index_val  (index_val),
      .disp       (disp),
      .scale_code (scale_code),
      .ea         (ea),
      .uses_base  (uses_base)
   );

   slag_seg_select #(.SEG_W(SEG_W)) u_seg (
      .uses_base     (uses_base),
      .base_is_stack (base_is_stack),
      .seg_data      (seg_data),
      .seg_stack     (seg_stack),
      .seg_sel       (sel_e),
      .seg_val       (seg_val)
   );

   assign seg_sel = sel_e;

   slag_lin_adder #(
      .EA_W(EA_W), .SEG_W(SEG_W), .SEG_SHIFT(SEG_SHIFT), .LIN_W(LIN_W)
   ) u_lin (
      .seg_val  (seg_val),
      .ea       (ea),
      .lin_addr (lin_addr)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            ea_q      <= '0;
            seg_sel_q <= 1'b0;
            lin_q     <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               ea_q      <= ea;
               seg_sel_q <= seg_sel;
               lin_q     <= lin_addr;
            end
         end
      end
   end else begin : g_pass
      assign out_valid = in_valid & rst_n;
      assign ea_q      = ea;
      assign seg_sel_q = seg_sel;
      assign lin_q     = lin_addr;
      logic unused_clk;
      assign unused_clk = clk;
   end

endmodule

// File: rtl/seg_lin_addr_gen_chk.sv
module seg_lin_addr_gen_chk #(
   parameter int EA_W  = 16,
   parameter int LIN_W = 20,
   parameter bit REG_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [2:0]       mode,
   input logic [EA_W-1:0]  base_val,
   input logic [EA_W-1:0]  disp,
   input logic             base_is_stack,
   input logic [EA_W-1:0]  ea,
   input logic             seg_sel,
   input logic [LIN_W-1:0] lin_addr,
   input logic             out_valid,
   input logic [EA_W-1:0]  ea_q,
   input logic [LIN_W-1:0] lin_q
);

   // R1
   lin_low_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lin_addr[3:0] == ea[3:0]);

   // R2
   direct_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd0) |-> (ea == disp && !seg_sel));

   // R3
   reg_ind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd1) |-> (ea == base_val));

   // R8
   stack_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode >= 3'd1 && mode <= 3'd5) |-> (seg_sel == base_is_stack));

   // R9
   reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode >= 3'd6) |-> (ea == disp && !seg_sel));

   if (REG_OUT) begin : g_reg_chk
      // R10
      capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> (out_valid && lin_q == $past(lin_addr) && ea_q == $past(ea)));
      // R10
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!out_valid && $stable(lin_q) && $stable(ea_q)));
   end

endmodule

bind seg_lin_addr_gen seg_lin_addr_gen_chk #(
   .EA_W(EA_W), .LIN_W(LIN_W), .REG_OUT(REG_OUT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
   .base_val(base_val), .disp(disp), .base_is_stack(base_is_stack),
   .ea(ea), .seg_sel(seg_sel), .lin_addr(lin_addr), .out_valid(out_valid),
   .ea_q(ea_q), .lin_q(lin_q)
);

// File: tb/seg_lin_addr_gen_tb.sv
`timescale 1ns/1ps
module seg_lin_addr_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  mode = '0;
   logic [15:0] base_val = '0, index_val = '0, disp = '0;
   logic [1:0]  scale_code = '0;
   logic        base_is_stack = 1'b0;
   logic [15:0] seg_data = '0, seg_stack = '0;
   logic [15:0] ea, ea_q;
   logic        seg_sel, seg_sel_q, out_valid;
   logic [19:0] lin_addr, lin_q;

   int checks = 0;
   int errors = 0;

   typedef struct { logic [15:0] ea; logic sel; logic [19:0] lin; string tag; } item_t;
   item_t exp_q[$];
   item_t last_item;

   always #2 clk = ~clk;

   seg_lin_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
      .base_val(base_val), .index_val(index_val), .disp(disp),
      .scale_code(scale_code), .base_is_stack(base_is_stack),
      .seg_data(seg_data), .seg_stack(seg_stack), .ea(ea), .seg_sel(seg_sel),
      .lin_addr(lin_addr), .out_valid(out_valid), .ea_q(ea_q),
      .seg_sel_q(seg_sel_q), .lin_q(lin_q)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic item_t model(input string tag);
      item_t it;
      int unsigned e;
      int unsigned sv;
      bit uses;
      uses = 1'b1;
      case (mode)
         3'd1: e = base_val;
         3'd2: e = base_val + index_val;
         3'd3: e = base_val + disp;
         3'd4: e = base_val + index_val + disp;
         3'd5: e = base_val + index_val * (1 << scale_code);
         default: begin e = disp; uses = 1'b0; end
      endcase
      it.ea  = e[15:0];
      it.sel = uses && base_is_stack;
      sv     = it.sel ? seg_stack : seg_data;
      it.lin = 20'((sv * 16 + it.ea) % (1 << 20));
      it.tag = tag;
      return it;
   endfunction

   task automatic drive(input string tag, input logic [2:0] m, input logic [15:0] b,
                        input logic [15:0] x, input logic [15:0] d, input logic [1:0] sc,
                        input logic stk, input logic [15:0] sd, input logic [15:0] ss);
      item_t it;
      @(negedge clk);
      mode = m; base_val = b; index_val = x; disp = d; scale_code = sc;
      base_is_stack = stk; seg_data = sd; seg_stack = ss; in_valid = 1'b1;
      #1;
      it = model(tag);
      chk(ea == it.ea, {tag, " ea"}, 32'(ea), 32'(it.ea));
      chk(seg_sel == it.sel, {tag, " R8 seg_sel"}, 32'(seg_sel), 32'(it.sel));
      chk(lin_addr == it.lin, {tag, " R1 lin"}, 32'(lin_addr), 32'(it.lin));
      exp_q.push_back(it);
      last_item = it;
   endtask

   // monitor / scoreboard
   always @(posedge clk) begin
      #1;
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R10 unexpected out_valid", 32'(out_valid), 32'd0);
         end else begin
            item_t it;
            it = exp_q.pop_front();
            chk(ea_q == it.ea, {it.tag, " R10 ea_q"}, 32'(ea_q), 32'(it.ea));
            chk(seg_sel_q == it.sel, {it.tag, " R10 seg_sel_q"}, 32'(seg_sel_q), 32'(it.sel));
            chk(lin_q == it.lin, {it.tag, " R10 lin_q"}, 32'(lin_q), 32'(it.lin));
         end
      end
   end

   initial begin
      #400000;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R11 out_valid in reset", 32'(out_valid), 0);
      chk(lin_q == '0, "R11 lin_q in reset", 32'(lin_q), 0);
      chk(ea_q == '0 && seg_sel_q == 1'b0, "R11 ea_q/seg_sel_q in reset",
          32'({ea_q, seg_sel_q}), 0);
      rst_n = 1'b1;

      drive("R2 direct",        3'd0, 16'h1111, 16'h2222, 16'h1000, 2'd3, 1'b1, 16'h2000, 16'h3000);
      drive("R3 reg-ind data",  3'd1, 16'h0456, 16'h0000, 16'h0000, 2'd0, 1'b0, 16'h1234, 16'h5678);
      drive("R3 reg-ind stack", 3'd1, 16'hABCD, 16'h0000, 16'h0000, 2'd0, 1'b1, 16'h1234, 16'h5678);
      drive("R4 based-idx",     3'd2, 16'h0100, 16'h0020, 16'h0000, 2'd0, 1'b0, 16'h0400, 16'h0800);
      drive("R4 wrap",          3'd2, 16'hFFFF, 16'h0002, 16'h0000, 2'd0, 1'b1, 16'h0400, 16'h0800);
      drive("R5 reg-rel",       3'd3, 16'h0010, 16'h9999, 16'h00F0, 2'd0, 1'b1, 16'h0001, 16'h0002);
      drive("R6 brel-idx",      3'd4, 16'h1000, 16'h0200, 16'h0030, 2'd0, 1'b0, 16'hA000, 16'hB000);
      drive("R6 wrap",          3'd4, 16'hF000, 16'h0F00, 16'h0101, 2'd0, 1'b1, 16'hA000, 16'hFFFF);
      for (int s = 0; s < 4; s++)
         drive("R7 scaled", 3'd5, 16'h0100, 16'h0011, 16'h0000, 2'(s), 1'b0, 16'h0050, 16'h0060);
      drive("R7 wrap both",     3'd5, 16'hFFF0, 16'h0004, 16'h0000, 2'd3, 1'b1, 16'h0000, 16'hFFFF);
      drive("R1 20-bit wrap",   3'd1, 16'hFFFF, 16'h0000, 16'h0000, 2'd0, 1'b1, 16'h0000, 16'hFFFF);
      drive("R9 code6",         3'd6, 16'h7777, 16'h1111, 16'h0ABC, 2'd1, 1'b1, 16'h0123, 16'h0456);
      drive("R9 code7",         3'd7, 16'h7777, 16'h1111, 16'h0DEF, 2'd2, 1'b1, 16'h0123, 16'h0456);
      // R12: scale differs, all else equal, in a non-scaled mode
      drive("R12 scale0",       3'd4, 16'h0300, 16'h0040, 16'h0005, 2'd0, 1'b0, 16'h0010, 16'h0020);
      drive("R12 scale3",       3'd4, 16'h0300, 16'h0040, 16'h0005, 2'd3, 1'b0, 16'h0010, 16'h0020);
      drive("R12 reg-rel scale",3'd3, 16'h0300, 16'h0040, 16'h0005, 2'd2, 1'b1, 16'h0010, 16'h0020);

      // R10 hold: drop in_valid and change inputs
      @(negedge clk);
      in_valid = 1'b0; mode = 3'd2; base_val = 16'h4321; index_val = 16'h1111;
      @(negedge clk);
      chk(out_valid == 1'b0, "R10 out_valid low when idle", 32'(out_valid), 0);
      chk(lin_q == last_item.lin, "R10 lin_q held", 32'(lin_q), 32'(last_item.lin));
      chk(ea_q == last_item.ea, "R10 ea_q held", 32'(ea_q), 32'(last_item.ea));
      chk(ea == 16'h5432, "R4 comb follows while idle", 32'(ea), 32'h5432);
      chk(exp_q.size() == 0, "R10 all items produced", 32'(exp_q.size()), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule